// File: doc/BRIEF.md
# Flash Bulk Transfer FIFO Engine

This block sits between a host register port and a flash back end and moves 32-bit data words through one shared FIFO. The host sees four word registers: a control register, an address pointer, a data port and an ownership register. To read, the host first obtains flash ownership. It then sets the address pointer and writes a control word that holds a word count and the read-mode flag. The engine fetches the words from flash into the FIFO while a busy flag stays high, and the host pops them from the data port. Writing the control register with the read-mode flag clear ends the block.

To write, the host sets the address pointer and pushes words through the data port. It watches the free-space field in the control register. The engine sends each queued word to the back end, one per ready handshake, at word addresses that count upward. A host that needs a byte length that is not a multiple of four rounds it up to whole words. The engine always moves complete 32-bit words.

Top module: `flash_bulk_engine`

## Requirements
- R1: After reset the busy flag (control bit 1) and the read-mode flag (control bit 0) are 0. The free-space field (control bits 29:24) reads 32. The owner field (ownership register bits 9:8) reads 2'b10, meaning not host, and `flashReq` is low.
- R2: An accepted read command (control write with bit 0 set and the count in bits 13:8) raises busy on the next cycle. It then fetches that many words with read requests, starting at the address pointer (register offset 1) and counting upward, and clears busy once the last word is in the FIFO.
- R3: A read count above the FIFO depth of 32 is cut to 32.
- R4: A read command is ignored when busy is high, or when the host-request bit (ownership register bit 0) is clear or ownership is not granted. It is also ignored while write data is still queued.
- R5: In read mode each data-port read (offset 2) pops one word, oldest first. A pop of an empty FIFO returns 0 and changes nothing.
- R6: A control write with bit 0 clear stops any fetch, clears busy and read mode, and empties the FIFO when read mode was set.
- R7: The free-space field always equals 32 minus the number of queued words.
- R8: A data-port write when the FIFO is full is dropped, and that word never reaches flash.
- R9: Outside read mode, pushed words go to the back end in push order. Each goes out on one write request held until `flashReady`, at word addresses that start at the address pointer and count upward.
- R10: The host-request bit drives `muxHostReq`. The owner field reads 2'b01 while `muxHostGrant` is high and 2'b10 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostRdEn | input | 1 | Host register read strobe (a data-port read pops) |
| hostAddr | input | 2 | Register select: 0 control, 1 address, 2 data, 3 ownership |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data, combinational from hostAddr |
| flashReq | output | 1 | Back-end request, held until flashReady |
| flashWe | output | 1 | 1 = write request, 0 = read request |
| flashAddr | output | 16 | Word address of the request |
| flashWData | output | 32 | Write data for a write request |
| flashRData | input | 32 | Read data, valid with flashReady |
| flashReady | input | 1 | Back end completes the current request |
| muxHostReq | output | 1 | Host asks for flash ownership |
| muxHostGrant | input | 1 | Ownership granted to the host |

## Verification
On every cycle the assertions check four things. Busy can rise only after a command made while ownership was requested and granted. A fetch issues only read requests. A pending request keeps its address and direction until the back end answers. The FIFO never holds more than its depth. They also check that an empty data-port pop reads zero and that a clearing control write leaves the engine idle. The bench scenarios cover what the assertions cannot: the order and values of fetched and written words, the cap on the count, dropped overflow words, and commands that must be ignored while busy or without ownership. These checks run against a flash model that has random latency and can be stalled.

// File: rtl/fbe_pkg.sv
package fbe_pkg;
  // Register offsets (word select on hostAddr)
  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_ADDR = 2'd1;
  localparam logic [1:0] OFS_DATA = 2'd2;
  localparam logic [1:0] OFS_MUX  = 2'd3;

  // Control register fields
  localparam int MODE_BIT  = 0;
  localparam int BUSY_BIT  = 1;
  localparam int CNT_LSB   = 8;
  localparam int FREE_LSB  = 24;
  localparam int FIELD_W   = 6;

  // Ownership register fields
  localparam int REQ_BIT   = 0;
  localparam int OWN_LSB   = 8;
  localparam logic [1:0] OWN_HOST  = 2'b01;
  localparam logic [1:0] OWN_OTHER = 2'b10;

  typedef enum logic {ST_IDLE, ST_FETCH} fetchState_e;

  typedef struct packed {
    logic push;
    logic pushFromFlash;
    logic pop;
    logic flush;
    logic loadAddr;
    logic incAddr;
  } fifoStrobes_t;
endpackage

// File: rtl/fbe_fifo.sv
module fbe_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       push,
  input  logic [DW-1:0]              pushData,
  input  logic                       pop,
  input  logic                       flush,
  output logic [DW-1:0]              headData,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign doPush = push && (count != FULL_CNT);
  assign doPop  = pop && !empty;
  assign headData = empty ? '0 : mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= pushData;
  end
endmodule

// File: rtl/fbe_datapath.sv
module fbe_datapath
  import fbe_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 16,
  parameter int DEPTH = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fifoStrobes_t           stb,
  input  logic [DW-1:0]          hostWrData,
  input  logic [DW-1:0]          flashRData,
  output logic [AW-1:0]          flashAddr,
  output logic [DW-1:0]          headData,
  output logic [$clog2(DEPTH):0] fifoCount,
  output logic                   fifoEmpty,
  output logic [FIELD_W-1:0]     freeSpace
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [DW-1:0] pushData;
  logic [AW-1:0] addrPtr;

  assign pushData = stb.pushFromFlash ? flashRData : hostWrData;

  fbe_fifo #(.DW(DW), .DEPTH(DEPTH)) uFifo (
    .clk(clk), .rstN(rstN),
    .push(stb.push), .pushData(pushData),
    .pop(stb.pop), .flush(stb.flush),
    .headData(headData), .count(fifoCount), .empty(fifoEmpty)
  );

  always_ff @(posedge clk) begin
    if (!rstN)             addrPtr <= '0;
    else if (stb.loadAddr) addrPtr <= hostWrData[AW-1:0];
    else if (stb.incAddr)  addrPtr <= addrPtr + 1'b1;
  end

  assign flashAddr = addrPtr;
  assign freeSpace = FIELD_W'(CW'(DEPTH) - fifoCount);
endmodule

// File: rtl/fbe_control.sv
module fbe_control
  import fbe_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic               hostRdEn,
  input  logic [1:0]         hostAddr,
  input  logic               cmdMode,
  input  logic [FIELD_W-1:0] cmdCount,
  input  logic               muxWrBit,
  input  logic               fifoEmpty,
  input  logic               flashReady,
  input  logic               muxHostGrant,
  output fifoStrobes_t       stb,
  output logic               busy,
  output logic               readMode,
  output logic [FIELD_W-1:0] blockCount,
  output logic               muxReq,
  output logic               flashReq,
  output logic               flashWe
);
  localparam logic [FIELD_W-1:0] CAP = FIELD_W'(DEPTH);

  fetchState_e state;
  logic [FIELD_W-1:0] remaining, capped;
  logic wrCtrl, wrAddrReg, wrData, wrMux, rdData;
  logic abort, accept, fetchBeat, drainReq, drainBeat;

  assign wrCtrl    = hostWrEn && (hostAddr == OFS_CTRL);
  assign wrAddrReg = hostWrEn && (hostAddr == OFS_ADDR);
  assign wrData    = hostWrEn && (hostAddr == OFS_DATA);
  assign wrMux     = hostWrEn && (hostAddr == OFS_MUX);
  assign rdData    = hostRdEn && (hostAddr == OFS_DATA);

  assign capped = (cmdCount > CAP) ? CAP : cmdCount;
  assign abort  = wrCtrl && !cmdMode;
  assign accept = wrCtrl && cmdMode && (state == ST_IDLE) && muxReq &&
                  muxHostGrant && (readMode || fifoEmpty);

  assign fetchBeat = (state == ST_FETCH) && flashReady && !abort;
  assign drainReq  = (state == ST_IDLE) && !readMode && !fifoEmpty;
  assign drainBeat = drainReq && flashReady;

  assign flashReq = (state == ST_FETCH) || drainReq;
  assign flashWe  = drainReq;
  assign busy     = (state == ST_FETCH);

  always_comb begin
    stb               = '0;
    stb.push          = fetchBeat || (wrData && !readMode);
    stb.pushFromFlash = fetchBeat;
    stb.pop           = (rdData && readMode) || drainBeat;
    stb.flush         = abort && readMode;
    stb.loadAddr      = wrAddrReg;
    stb.incAddr       = fetchBeat || drainBeat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      readMode   <= 1'b0;
      remaining  <= '0;
      blockCount <= '0;
      muxReq     <= 1'b0;
    end else begin
      if (wrMux) muxReq <= muxWrBit;
      if (abort) begin
        state      <= ST_IDLE;
        readMode   <= 1'b0;
        remaining  <= '0;
        blockCount <= '0;
      end else if (accept) begin
        readMode   <= 1'b1;
        blockCount <= capped;
        remaining  <= capped;
        state      <= (capped == '0) ? ST_IDLE : ST_FETCH;
      end else if (fetchBeat) begin
        remaining <= remaining - 1'b1;
        if (remaining == FIELD_W'(1)) state <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/flash_bulk_engine.sv
module flash_bulk_engine
  import fbe_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 16,
  parameter int FIFO_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [1:0]        hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic              flashReq,
  output logic              flashWe,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashWData,
  input  logic [DATA_W-1:0] flashRData,
  input  logic              flashReady,
  output logic              muxHostReq,
  input  logic              muxHostGrant
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;

  fifoStrobes_t       stb;
  logic               busy, readMode, fifoEmpty;
  logic [FIELD_W-1:0] blockCount, freeSpace;
  logic [CW-1:0]      fifoCount;
  logic [DATA_W-1:0]  headData;

  fbe_control #(.DEPTH(FIFO_DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostAddr(hostAddr),
    .cmdMode(hostWrData[MODE_BIT]),
    .cmdCount(hostWrData[CNT_LSB +: FIELD_W]),
    .muxWrBit(hostWrData[REQ_BIT]),
    .fifoEmpty(fifoEmpty), .flashReady(flashReady), .muxHostGrant(muxHostGrant),
    .stb(stb), .busy(busy), .readMode(readMode), .blockCount(blockCount),
    .muxReq(muxHostReq), .flashReq(flashReq), .flashWe(flashWe)
  );

  fbe_datapath #(.DW(DATA_W), .AW(ADDR_W), .DEPTH(FIFO_DEPTH)) uData (
    .clk(clk), .rstN(rstN), .stb(stb),
    .hostWrData(hostWrData), .flashRData(flashRData),
    .flashAddr(flashAddr), .headData(headData),
    .fifoCount(fifoCount), .fifoEmpty(fifoEmpty), .freeSpace(freeSpace)
  );

  assign flashWData = headData;

  always_comb begin
    hostRdData = '0;
    unique case (hostAddr)
      OFS_CTRL: begin
        hostRdData[MODE_BIT]             = readMode;
        hostRdData[BUSY_BIT]             = busy;
        hostRdData[CNT_LSB +: FIELD_W]   = blockCount;
        hostRdData[FREE_LSB +: FIELD_W]  = freeSpace;
      end
      OFS_ADDR: hostRdData[ADDR_W-1:0] = flashAddr;
      OFS_DATA: hostRdData = readMode ? headData : '0;
      OFS_MUX: begin
        hostRdData[REQ_BIT]      = muxHostReq;
        hostRdData[OWN_LSB +: 2] = muxHostGrant ? OWN_HOST : OWN_OTHER;
      end
      default: hostRdData = '0;
    endcase
  end
endmodule

// File: rtl/fbe_checker.sv
module fbe_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 32,
  parameter int CW     = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWrEn,
  input logic              hostRdEn,
  input logic [1:0]        hostAddr,
  input logic [DATA_W-1:0] hostWrData,
  input logic [DATA_W-1:0] hostRdData,
  input logic              flashReq,
  input logic              flashWe,
  input logic [ADDR_W-1:0] flashAddr,
  input logic              flashReady,
  input logic              muxHostReq,
  input logic              muxHostGrant,
  input logic              busy,
  input logic              readMode,
  input logic [CW-1:0]     fifoCount
);
  // R4: a fetch only starts after a command issued with ownership granted
  assert_fetch_needs_grant_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(muxHostGrant && muxHostReq));

  // R2: while busy the engine issues read requests only
  assert_fetch_reads_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (flashReq && !flashWe));

  // R8: occupancy never exceeds the depth
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CW'(DEPTH));

  // R9: an unanswered request stays put
  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flashReq && !flashReady && !hostWrEn) |=>
      (flashReq && $stable(flashAddr) && $stable(flashWe)));

  // R5: popping an empty FIFO reads zero
  assert_empty_pop_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && hostAddr == 2'd2 && fifoCount == '0) |-> (hostRdData == '0));

  // R6: a clearing control write leaves the engine idle
  assert_clear_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == 2'd0 && !hostWrData[0]) |=> (!busy && !readMode));
endmodule

bind flash_bulk_engine fbe_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH), .CW(CW)
) uChk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
  .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
  .flashReq(flashReq), .flashWe(flashWe), .flashAddr(flashAddr),
  .flashReady(flashReady), .muxHostReq(muxHostReq), .muxHostGrant(muxHostGrant),
  .busy(busy), .readMode(readMode), .fifoCount(fifoCount)
);

// File: tb/flash_bulk_engine_test.sv
module flash_bulk_engine_test;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [1:0] hostAddr = 2'd0;
  logic [DW-1:0] hostWrData = '0;
  logic [DW-1:0] hostRdData;
  logic flashReq, flashWe;
  logic [AW-1:0] flashAddr;
  logic [DW-1:0] flashWData;
  logic [DW-1:0] flashRData = '0;
  logic flashReady = 1'b0;
  logic muxHostReq;
  logic muxHostGrant = 1'b0;

  logic [DW-1:0] flashMem [256];
  logic stall = 1'b0;
  int checkCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  flash_bulk_engine #(.DATA_W(DW), .ADDR_W(AW), .FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .flashReq(flashReq), .flashWe(flashWe), .flashAddr(flashAddr),
    .flashWData(flashWData), .flashRData(flashRData), .flashReady(flashReady),
    .muxHostReq(muxHostReq), .muxHostGrant(muxHostGrant)
  );

  function automatic logic [31:0] seedWord(int i);
    return (32'(i) * 32'h9E3779B1) ^ 32'hA5C30000;
  endfunction

  function automatic int bytesToWords(int nBytes);
    return (nBytes + 3) / 4;
  endfunction

  function automatic logic [31:0] ctrlWord(int cnt, bit mode);
    return (32'(cnt) << 8) | {31'b0, mode};
  endfunction

  // flash back end model with random latency and a stall knob
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk);
      if (flashReady) flashReady = 1'b0;
      else if (flashReq && !stall) begin
        if (lat == 0) begin
          flashReady = 1'b1;
          if (flashWe) flashMem[flashAddr[7:0]] = flashWData;
          else flashRData = flashMem[flashAddr[7:0]];
          lat = $urandom_range(0, 3);
        end else lat--;
      end
    end
  end

  // ownership grant follows the request after three cycles
  initial begin
    logic [2:0] pipe = 3'b0;
    forever begin
      @(negedge clk);
      pipe = {pipe[1:0], muxHostReq};
      muxHostGrant = pipe[2];
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL R2 watchdog: actual still running, expected finished");
      summary();
      $finish;
    end
  end

  task automatic checkVal(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    hostRdEn = 1'b1; hostAddr = a;
    #1 d = hostRdData;
    @(negedge clk);
    hostRdEn = 1'b0;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 500; i++) begin
      regRead(2'd0, v);
      if (!v[1]) break;
    end
  endtask

  task automatic waitDrained();
    logic [31:0] v;
    for (int i = 0; i < 500; i++) begin
      regRead(2'd0, v);
      if (v[29:24] == 6'd32 && !flashReq) break;
    end
  endtask

  task automatic waitOwner(input logic [1:0] want);
    logic [31:0] v;
    for (int i = 0; i < 50; i++) begin
      regRead(2'd3, v);
      if (v[9:8] == want) break;
    end
  endtask

  // pop n words and compare against the flash model from base
  task automatic popCompare(input string req, input int base, input int n);
    logic [31:0] v;
    for (int i = 0; i < n; i++) begin
      regRead(2'd2, v);
      checkVal(req, "popped word", v, flashMem[(base + i) & 255]);
    end
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] wbuf [40];
    logic [31:0] saved0, saved1;
    void'($urandom(32'd7321));
    for (int i = 0; i < 256; i++) flashMem[i] = seedWord(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(2'd0, v);
    checkVal("R1", "busy/mode", {30'b0, v[1:0]}, 32'd0);
    checkVal("R1", "free space", {26'b0, v[29:24]}, 32'd32);
    regRead(2'd3, v);
    checkVal("R1", "owner field", {30'b0, v[9:8]}, 32'd2);
    checkVal("R1", "flashReq", {31'b0, flashReq}, 32'd0);

    // R4 read command without ownership is ignored
    regWrite(2'd1, 32'h5);
    regWrite(2'd0, ctrlWord(4, 1));
    repeat (4) @(negedge clk);
    regRead(2'd0, v);
    checkVal("R4", "no-grant busy/mode", {30'b0, v[1:0]}, 32'd0);
    checkVal("R4", "no-grant free", {26'b0, v[29:24]}, 32'd32);

    // R10 acquire ownership
    regWrite(2'd3, 32'h1);
    checkVal("R10", "muxHostReq", {31'b0, muxHostReq}, 32'd1);
    waitOwner(2'b01);
    regRead(2'd3, v);
    checkVal("R10", "owner host", {30'b0, v[9:8]}, 32'd1);

    // R2 directed read of 8 words
    stall = 1'b1;
    regWrite(2'd1, 32'h10);
    regWrite(2'd0, ctrlWord(8, 1));
    regRead(2'd0, v);
    checkVal("R2", "busy while fetching", {31'b0, v[1]}, 32'd1);
    stall = 1'b0;
    waitIdle();
    regRead(2'd0, v);
    checkVal("R7", "free after 8", {26'b0, v[29:24]}, 32'd24);
    popCompare("R2", 32'h10, 8);
    regRead(2'd2, v);
    checkVal("R5", "empty pop", v, 32'd0);
    regRead(2'd0, v);
    checkVal("R5", "free after empty pop", {26'b0, v[29:24]}, 32'd32);
    regWrite(2'd0, 32'd0);

    // R3 count capped at depth
    regWrite(2'd1, 32'h40);
    regWrite(2'd0, ctrlWord(40, 1));
    waitIdle();
    regRead(2'd0, v);
    checkVal("R3", "count field", {26'b0, v[13:8]}, 32'd32);
    checkVal("R3", "free when full", {26'b0, v[29:24]}, 32'd0);
    popCompare("R3", 32'h40, 32);
    regRead(2'd2, v);
    checkVal("R3", "nothing beyond 32", v, 32'd0);
    regWrite(2'd0, 32'd0);

    // R4 command while busy is ignored
    stall = 1'b1;
    regWrite(2'd1, 32'h20);
    regWrite(2'd0, ctrlWord(4, 1));
    regWrite(2'd0, ctrlWord(10, 1));
    regRead(2'd0, v);
    checkVal("R4", "count kept while busy", {26'b0, v[13:8]}, 32'd4);
    stall = 1'b0;
    waitIdle();
    regRead(2'd0, v);
    checkVal("R4", "free after busy ignore", {26'b0, v[29:24]}, 32'd28);
    popCompare("R4", 32'h20, 4);
    regWrite(2'd0, 32'd0);

    // R6 abort during a fetch
    stall = 1'b1;
    regWrite(2'd1, 32'h30);
    regWrite(2'd0, ctrlWord(6, 1));
    regWrite(2'd0, 32'd0);
    regRead(2'd0, v);
    checkVal("R6", "busy/mode after clear", {30'b0, v[1:0]}, 32'd0);
    checkVal("R6", "free after clear", {26'b0, v[29:24]}, 32'd32);
    checkVal("R6", "flashReq after clear", {31'b0, flashReq}, 32'd0);
    stall = 1'b0;

    // R2 random reads split into blocks of at most 32 words
    for (int r = 0; r < 6; r++) begin
      int addr = $urandom_range(0, 150);
      int rem = bytesToWords($urandom_range(1, 160));
      while (rem > 0) begin
        int blk = (rem > DEPTH) ? DEPTH : rem;
        regWrite(2'd1, 32'(addr));
        regWrite(2'd0, ctrlWord(blk, 1));
        waitIdle();
        regRead(2'd0, v);
        checkVal("R7", "free after block", {26'b0, v[29:24]}, 32'(DEPTH - blk));
        popCompare("R2", addr, blk);
        regWrite(2'd0, 32'd0);
        addr += blk;
        rem -= blk;
      end
    end

    // R10 release ownership
    regWrite(2'd3, 32'h0);
    checkVal("R10", "muxHostReq low", {31'b0, muxHostReq}, 32'd0);
    waitOwner(2'b10);
    regRead(2'd3, v);
    checkVal("R10", "owner other", {30'b0, v[9:8]}, 32'd2);

    // R7 free space while writes are queued
    stall = 1'b1;
    regWrite(2'd1, 32'hA0);
    for (int i = 0; i < 5; i++) begin
      wbuf[i] = $urandom();
      regWrite(2'd2, wbuf[i]);
    end
    regRead(2'd0, v);
    checkVal("R7", "free with 5 queued", {26'b0, v[29:24]}, 32'd27);
    stall = 1'b0;
    waitDrained();
    for (int i = 0; i < 5; i++) checkVal("R9", "written word", flashMem[8'hA0 + i], wbuf[i]);

    // R9 random write bursts
    for (int r = 0; r < 4; r++) begin
      int base = $urandom_range(0, 200);
      int n = $urandom_range(1, 32);
      regWrite(2'd1, 32'(base));
      for (int i = 0; i < n; i++) begin
        wbuf[i] = $urandom();
        regWrite(2'd2, wbuf[i]);
      end
      waitDrained();
      for (int i = 0; i < n; i++) checkVal("R9", "burst word", flashMem[base + i], wbuf[i]);
    end

    // R8 pushes into a full FIFO are dropped
    saved0 = flashMem[8'hE0];
    saved1 = flashMem[8'hE1];
    stall = 1'b1;
    regWrite(2'd1, 32'hC0);
    for (int i = 0; i < 34; i++) begin
      wbuf[i] = $urandom();
      regWrite(2'd2, wbuf[i]);
    end
    regRead(2'd0, v);
    checkVal("R8", "free when full", {26'b0, v[29:24]}, 32'd0);
    stall = 1'b0;
    waitDrained();
    for (int i = 0; i < 32; i++) checkVal("R8", "kept word", flashMem[8'hC0 + i], wbuf[i]);
    checkVal("R8", "dropped word 33", flashMem[8'hE0], saved0);
    checkVal("R8", "dropped word 34", flashMem[8'hE1], saved1);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule